// File: doc/BRIEF.md
# Four-Word Control Register Loader

This block loads one logical configuration into a single physical control register of an entropy source by writing four 64-bit control words to it, one after another. The first three words each set the oscillator rate of one noise cell and enable only that cell. The fourth word holds the final setting, with all three cell enables and the mode bit set, and it is the value that remains in the register. A target state code travels with every write.

After the fourth write is acknowledged, the loader issues a read-back of the control register and waits for it to succeed, so the requester knows the configuration has taken effect. The register port answers each access with one of four response codes. A busy answer is retried after a fixed delay of one microsecond, counted in clock cycles. A would-block answer is retried after the tick delay that comes with it. Each kind of retry has its own give-up limit. A fault answer ends the load at once. When the load ends, the block reports one status code and is then ready for the next request. A request that arrives while a load is running is refused.

Top module: `ctlreg_quad_loader`

## Requirements
- R1: `ld_ready` is 1 exactly when no load is in progress. A cycle with `ld_valid`=1 and `ld_ready`=1 captures `ld_words` and `ld_state`. `ld_valid` asserted while `ld_ready`=0 has no effect on the words, the state code or the access sequence.
- R2: A load writes word i, taken from `ld_words[64*i +: 64]`, for i = 0, 1, 2, 3 in that order. Each write has `rp_write`=1, `rp_index`=i and `rp_state` equal to the captured target code (0 unconfigured, 1 configured, 2 health-check, 3 error). `rp_valid` is a one-cycle pulse, and at most one access is outstanding at any time.
- R3: After the OK answer to word 3, exactly one read-back is issued (`rp_write`=0, `rp_index`=3). An OK answer to it ends the load with status 0 (done).
- R4: Response codes are 0 OK, 1 busy, 2 would-block and 3 fault. A busy answer in response cycle c makes the same access reappear on `rp_valid` in cycle c+CYC_PER_US+1. An OK answer in cycle c makes the next access appear in cycle c+1.
- R5: A would-block answer with tick delay t in cycle c makes the same access reappear in cycle c+max(t,1)+1.
- R6: The BUSY_LIMIT-th busy answer to one access ends the load with status 1 and issues no further access. Busy and would-block counts restart at 0 for every new access.
- R7: The BLOCK_LIMIT-th would-block answer to one access ends the load with status 2.
- R8: A fault answer to any access ends the load with status 3 at once.
- R9: `ld_done` is a one-cycle pulse in the cycle after the final response. In that cycle `ld_status` holds the status and `ld_ready` is 1.
- R10: After reset, `ld_ready`=1, `ld_done`=0 and `rp_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ld_valid | input | 1 | Load request |
| ld_ready | output | 1 | Idle and able to accept a load |
| ld_words | input | 4*WORD_W | Four control words, word i at bits [WORD_W*i +: WORD_W] |
| ld_state | input | 2 | Target state code |
| ld_done | output | 1 | Load finished (one-cycle pulse) |
| ld_status | output | 2 | 0 done, 1 busy give-up, 2 would-block give-up, 3 fault |
| rp_valid | output | 1 | Register access request (one-cycle pulse) |
| rp_write | output | 1 | 1 for a write, 0 for the read-back |
| rp_index | output | 2 | Index of the word being written |
| rp_wdata | output | WORD_W | Word being written |
| rp_state | output | 2 | Target state code sent with the access |
| rp_resp_valid | input | 1 | Response present |
| rp_resp_code | input | 2 | 0 OK, 1 busy, 2 would-block, 3 fault |
| rp_resp_ticks | input | TICK_W | Retry delay in cycles for a would-block answer |

## Verification
The assertions take it for granted that the register port answers each access exactly once, with a single-cycle `rp_resp_valid` and never before the access has been issued. The stimulus keeps to this by answering only after it has seen `rp_valid`, with a latency of one to three cycles, and by driving the response for a single cycle. Load requests made during a load are sent on purpose, because the design must refuse them.

// File: rtl/rld_pkg.sv
`timescale 1ns/1ps
// Shared types for the four-word control register loader.
// Assumes: four words per load, 2-bit response, status and state codes.
package rld_pkg;
    localparam int NUM_WORDS = 4;

    typedef enum logic [1:0] {RSP_OK = 2'd0, RSP_BUSY = 2'd1, RSP_BLOCK = 2'd2, RSP_FAULT = 2'd3} rsp_e;
    typedef enum logic [1:0] {LD_OK = 2'd0, LD_BUSY = 2'd1, LD_BLOCK = 2'd2, LD_FAULT = 2'd3} ldst_e;
    typedef enum logic [1:0] {TGT_UNCONF = 2'd0, TGT_CONF = 2'd1, TGT_HEALTH = 2'd2, TGT_ERROR = 2'd3} tgt_e;
    typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT, S_DELAY} fsm_e;

    // Field positions of one control word (cell enables, mode, rate, wait).
    localparam int EN_LSB   = 0;
    localparam int MODE_BIT = 3;
    localparam int RATE_LSB = 6;
    localparam int WAIT_LSB = 9;

    // Builds a control word from its fields.
    function automatic logic [63:0] cell_word(input logic [1:0] rate, input logic [2:0] en,
                                              input logic mode, input logic [15:0] wait_cyc);
        logic [63:0] w;
        w = '0;
        w[EN_LSB +: 3]    = en;
        w[MODE_BIT]       = mode;
        w[RATE_LSB +: 2]  = rate;
        w[WAIT_LSB +: 16] = wait_cyc;
        return w;
    endfunction
endpackage

// File: rtl/rld_limit_cnt.sv
`timescale 1ns/1ps
// Counts retries of one kind and flags when the next one reaches the limit.
// Assumes: LIMIT >= 1; the owner never increments once last is set.
module rld_limit_cnt #(
    parameter int LIMIT = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic last
);
    localparam int CW = (LIMIT > 1) ? $clog2(LIMIT + 1) : 1;

    logic [CW-1:0] cnt_q;

    // Retry count: cleared per access, stepped per retry.
    always_ff @(posedge clk) begin
        if (!rst_n)     cnt_q <= '0;
        else if (clr)   cnt_q <= '0;
        else if (inc)   cnt_q <= cnt_q + 1'b1;
    end

    assign last = (cnt_q == CW'(LIMIT - 1));

    AST_NO_INC_AT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        inc |-> !last); // R6
    AST_CLR_INC_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(clr && inc)); // R6
endmodule

// File: rtl/rld_delay_timer.sv
`timescale 1ns/1ps
// Down-counter that holds off a retry for a loaded number of cycles.
// Assumes: load is nonzero and start comes only while the timer is idle.
module rld_delay_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] load,
    output logic         expire,
    output logic         running
);
    logic [W-1:0] cnt_q;

    // Remaining delay cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt_q <= '0;
        else if (start)        cnt_q <= load;
        else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end

    assign running = (cnt_q != '0);
    assign expire  = (cnt_q == W'(1));

    AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !running); // R4
    AST_LOAD_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> (load != '0)); // R5
endmodule

// File: rtl/ctlreg_quad_loader.sv
`timescale 1ns/1ps
// Loads four control words into one register in index order, confirms with a
// read-back, retries busy and would-block answers with bounded counts.
// Assumes: one response per access, one cycle long, after the access.
module ctlreg_quad_loader
    import rld_pkg::*;
#(
    parameter int WORD_W      = 64,
    parameter int CYC_PER_US  = 100,
    parameter int BUSY_LIMIT  = 100,
    parameter int BLOCK_LIMIT = 60000,
    parameter int TICK_W      = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          ld_valid,
    output logic                          ld_ready,
    input  logic [NUM_WORDS*WORD_W-1:0]   ld_words,
    input  logic [1:0]                    ld_state,
    output logic                          ld_done,
    output logic [1:0]                    ld_status,
    output logic                          rp_valid,
    output logic                          rp_write,
    output logic [1:0]                    rp_index,
    output logic [WORD_W-1:0]             rp_wdata,
    output logic [1:0]                    rp_state,
    input  logic                          rp_resp_valid,
    input  logic [1:0]                    rp_resp_code,
    input  logic [TICK_W-1:0]             rp_resp_ticks
);
    localparam int US_W  = $clog2(CYC_PER_US + 1);
    localparam int DLY_W = (US_W > TICK_W) ? US_W : TICK_W;
    localparam logic [1:0] LAST_IDX = 2'(NUM_WORDS - 1);

    fsm_e              st_q;
    logic [WORD_W-1:0] word_q [NUM_WORDS];
    logic [1:0]        idx_q;
    logic [1:0]        tgt_q;
    logic              rdback_q;
    logic              done_q;
    ldst_e             status_q;

    logic              accept, take;
    rsp_e              code;
    logic [1:0]        lim_clr, lim_inc, lim_last;
    logic              tmr_start, tmr_expire, tmr_running;
    logic [DLY_W-1:0]  tmr_load;

    assign accept = (st_q == S_IDLE) && ld_valid;
    assign take   = (st_q == S_WAIT) && rp_resp_valid;
    assign code   = rsp_e'(rp_resp_code);

    // Retry bookkeeping: index 0 counts busy answers, index 1 would-block answers.
    always_comb begin
        lim_clr    = {2{accept || (take && code == RSP_OK)}};
        lim_inc[0] = take && (code == RSP_BUSY)  && !lim_last[0];
        lim_inc[1] = take && (code == RSP_BLOCK) && !lim_last[1];
        tmr_start  = |lim_inc;
        if (code == RSP_BUSY)          tmr_load = DLY_W'(CYC_PER_US);
        else if (rp_resp_ticks == '0)  tmr_load = DLY_W'(1);
        else                           tmr_load = DLY_W'(rp_resp_ticks);
    end

    for (genvar g = 0; g < 2; g++) begin : g_lim
        rld_limit_cnt #(.LIMIT(g == 0 ? BUSY_LIMIT : BLOCK_LIMIT)) u_lim (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (lim_clr[g]),
            .inc   (lim_inc[g]),
            .last  (lim_last[g])
        );
    end

    rld_delay_timer #(.W(DLY_W)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (tmr_start),
        .load    (tmr_load),
        .expire  (tmr_expire),
        .running (tmr_running)
    );

    // Word storage captured on acceptance.
    always_ff @(posedge clk) begin
        if (accept) begin
            for (int i = 0; i < NUM_WORDS; i++)
                word_q[i] <= ld_words[i*WORD_W +: WORD_W];
        end
    end

    // Sequencer: issue, wait for answer, advance, retry or finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= S_IDLE;
            idx_q    <= '0;
            tgt_q    <= '0;
            rdback_q <= 1'b0;
            done_q   <= 1'b0;
            status_q <= LD_OK;
        end else begin
            done_q <= 1'b0;
            case (st_q)
                S_IDLE: if (accept) begin
                    tgt_q    <= ld_state;
                    idx_q    <= '0;
                    rdback_q <= 1'b0;
                    st_q     <= S_ISSUE;
                end
                S_ISSUE: st_q <= S_WAIT;
                S_WAIT: if (take) begin
                    case (code)
                        RSP_OK: begin
                            if (rdback_q) begin
                                st_q <= S_IDLE; done_q <= 1'b1; status_q <= LD_OK;
                            end else begin
                                if (idx_q == LAST_IDX) rdback_q <= 1'b1;
                                else                   idx_q    <= idx_q + 1'b1;
                                st_q <= S_ISSUE;
                            end
                        end
                        RSP_BUSY: begin
                            if (lim_last[0]) begin
                                st_q <= S_IDLE; done_q <= 1'b1; status_q <= LD_BUSY;
                            end else st_q <= S_DELAY;
                        end
                        RSP_BLOCK: begin
                            if (lim_last[1]) begin
                                st_q <= S_IDLE; done_q <= 1'b1; status_q <= LD_BLOCK;
                            end else st_q <= S_DELAY;
                        end
                        default: begin
                            st_q <= S_IDLE; done_q <= 1'b1; status_q <= LD_FAULT;
                        end
                    endcase
                end
                S_DELAY: if (tmr_expire) st_q <= S_ISSUE;
                default: st_q <= S_IDLE;
            endcase
        end
    end

    assign ld_ready  = (st_q == S_IDLE);
    assign ld_done   = done_q;
    assign ld_status = status_q;
    assign rp_valid  = (st_q == S_ISSUE);
    assign rp_write  = !rdback_q;
    assign rp_index  = idx_q;
    assign rp_wdata  = word_q[idx_q];
    assign rp_state  = tgt_q;

    AST_NO_ACCESS_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        ld_ready |-> !rp_valid); // R1
    AST_SINGLE_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        rp_valid |=> !rp_valid); // R2
    AST_READBACK_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (rp_valid && !rp_write) |-> (rp_index == LAST_IDX)); // R3
    AST_DELAY_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_running |-> !rp_valid); // R4
    AST_BUSY_GIVEUP: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_done && ld_status == LD_BUSY) |-> $past(rp_resp_valid && rp_resp_code == RSP_BUSY)); // R6
    AST_BLOCK_GIVEUP: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_done && ld_status == LD_BLOCK) |-> $past(rp_resp_valid && rp_resp_code == RSP_BLOCK)); // R7
    AST_FAULT_END: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_done && ld_status == LD_FAULT) |-> $past(rp_resp_valid && rp_resp_code == RSP_FAULT)); // R8
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        ld_done |=> !ld_done); // R9
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        ld_done |-> ld_ready); // R9
endmodule

// File: tb/ctlreg_quad_loader_tb.sv
`timescale 1ns/1ps
module ctlreg_quad_loader_tb;
    import rld_pkg::*;

    localparam int CYC = 4;
    localparam int BL  = 5;
    localparam int KL  = 6;
    localparam int TW  = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         ld_valid = 1'b0;
    logic         ld_ready;
    logic [255:0] ld_words = '0;
    logic [1:0]   ld_state = '0;
    logic         ld_done;
    logic [1:0]   ld_status;
    logic         rp_valid, rp_write;
    logic [1:0]   rp_index, rp_state;
    logic [63:0]  rp_wdata;
    logic         rp_resp_valid = 1'b0;
    logic [1:0]   rp_resp_code = '0;
    logic [TW-1:0] rp_resp_ticks = '0;

    int n_cmp = 0;
    int n_bad = 0;
    int scr_code [0:31];
    int scr_tick [0:31];

    always #5 clk = ~clk;

    ctlreg_quad_loader #(.WORD_W(64), .CYC_PER_US(CYC), .BUSY_LIMIT(BL),
                         .BLOCK_LIMIT(KL), .TICK_W(TW)) u_dut (
        .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_ready(ld_ready),
        .ld_words(ld_words), .ld_state(ld_state), .ld_done(ld_done),
        .ld_status(ld_status), .rp_valid(rp_valid), .rp_write(rp_write),
        .rp_index(rp_index), .rp_wdata(rp_wdata), .rp_state(rp_state),
        .rp_resp_valid(rp_resp_valid), .rp_resp_code(rp_resp_code),
        .rp_resp_ticks(rp_resp_ticks)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // Expected cycles from a response to the next access (R4, R5).
    function automatic int exp_gap(input int code, input int tk);
        if (code == 1) return CYC + 1;
        if (code == 2) return ((tk == 0) ? 1 : tk) + 1;
        return 1;
    endfunction

    // Runs one load; answers from the script first, then random or OK.
    task automatic do_load(input logic [255:0] w, input logic [1:0] s,
                           input int nscr, input bit rnd, input bit poke);
        int phase, bc, kc, gap_e, g, rn, code, tk, lat, exp_st;
        bit fin;
        string tag;
        chk(ld_ready === 1'b1, "R1 ready before load", ld_ready, 1);
        ld_words = w; ld_state = s; ld_valid = 1'b1;
        @(negedge clk);
        ld_valid = 1'b0; ld_words = ~w;
        phase = 0; bc = 0; kc = 0; gap_e = 1; g = 1; rn = 0; fin = 0; exp_st = 0; tag = "R2";
        while (!fin) begin
            while (!rp_valid && !ld_done && g < 3000) begin
                @(negedge clk); g++;
            end
            if (!rp_valid) begin
                chk(1'b0, "R2 access missing", g, gap_e);
                fin = 1;
            end else begin
                chk(g == gap_e, {tag, " access timing"}, g, gap_e);
                chk(rp_write == (phase < 4), "R3 write or read-back", rp_write, phase < 4);
                chk(rp_index == ((phase < 4) ? phase : 3), "R2 index order", rp_index, (phase < 4) ? phase : 3);
                if (phase < 4)
                    chk(rp_wdata == w[phase*64 +: 64], "R2 word data", rp_wdata, w[phase*64 +: 64]);
                chk(rp_state == s, "R2 target state", rp_state, s);
                lat = 1 + int'($urandom % 3);
                for (int i = 0; i < lat; i++) begin
                    @(negedge clk);
                    if (poke && i == 0 && phase == 1) begin
                        chk(ld_ready == 1'b0, "R1 busy refuses", ld_ready, 0);
                        ld_valid = 1'b1; ld_words = {8{$urandom}}; ld_state = ~s;
                    end else begin
                        ld_valid = 1'b0;
                    end
                    chk(rp_valid == 1'b0, "R2 single outstanding", rp_valid, 0);
                end
                ld_valid = 1'b0;
                if (rn < nscr) begin
                    code = scr_code[rn]; tk = scr_tick[rn];
                end else if (rnd) begin
                    int r;
                    r = int'($urandom % 100);
                    code = (r < 55) ? 0 : (r < 75) ? 1 : (r < 94) ? 2 : 3;
                    tk = int'($urandom % 6);
                end else begin
                    code = 0; tk = 0;
                end
                rn++;
                rp_resp_valid = 1'b1; rp_resp_code = 2'(code); rp_resp_ticks = TW'(tk);
                case (code)
                    0: begin
                        phase++; bc = 0; kc = 0; tag = "R4 after OK";
                        if (phase == 5) begin fin = 1; exp_st = 0; tag = "R3"; end
                    end
                    1: begin
                        bc++; tag = "R4 busy retry";
                        if (bc == BL) begin fin = 1; exp_st = 1; tag = "R6"; end
                    end
                    2: begin
                        kc++; tag = "R5 block retry";
                        if (kc == KL) begin fin = 1; exp_st = 2; tag = "R7"; end
                    end
                    default: begin fin = 1; exp_st = 3; tag = "R8"; end
                endcase
                gap_e = exp_gap(code, tk);
                @(negedge clk);
                rp_resp_valid = 1'b0; g = 1;
                if (fin) begin
                    chk(ld_done == 1'b1, {tag, " done pulse"}, ld_done, 1);
                    chk(ld_status == 2'(exp_st), {tag, " status"}, ld_status, exp_st);
                    chk(ld_ready == 1'b1, "R9 ready with done", ld_ready, 1);
                    @(negedge clk);
                    chk(ld_done == 1'b0, "R9 done one cycle", ld_done, 0);
                    chk(rp_valid == 1'b0, "R6 no access after end", rp_valid, 0);
                end
            end
        end
    endtask

    initial begin
        logic [255:0] w;
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        chk(ld_ready == 1'b1, "R10 ready in reset", ld_ready, 1);
        chk(ld_done == 1'b0, "R10 done in reset", ld_done, 0);
        chk(rp_valid == 1'b0, "R10 no access in reset", rp_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Recommended words: three per-cell words, then the final one.
        w = {cell_word(2'd0, 3'b111, 1'b1, 16'd2048), cell_word(2'd3, 3'b100, 1'b1, 16'd2048),
             cell_word(2'd2, 3'b010, 1'b1, 16'd2048), cell_word(2'd1, 3'b001, 1'b1, 16'd2048)};
        do_load(w, TGT_CONF, 0, 0, 0);                      // R2 R3

        for (int i = 0; i < BL; i++) begin scr_code[i] = 1; scr_tick[i] = 0; end
        do_load({8{$urandom}}, TGT_HEALTH, BL, 0, 0);       // R6

        for (int i = 0; i < KL; i++) begin scr_code[i] = 2; scr_tick[i] = (i % 2) ? 5 : 0; end
        do_load({8{$urandom}}, TGT_UNCONF, KL, 0, 0);       // R5 R7

        for (int i = 0; i < 2*BL; i++) begin scr_code[i] = 1; scr_tick[i] = 0; end
        scr_code[BL-1] = 0; scr_code[2*BL-1] = 0;
        do_load({8{$urandom}}, TGT_CONF, 2*BL, 0, 0);       // R6 counts restart

        for (int i = 0; i < 5; i++) begin scr_code[i] = 0; scr_tick[i] = 0; end
        scr_code[4] = 3;
        do_load({8{$urandom}}, TGT_ERROR, 5, 0, 0);         // R8 on read-back

        do_load({8{$urandom}}, TGT_CONF, 0, 0, 1);          // R1 refused request

        for (int n = 0; n < 40; n++)
            do_load({8{$urandom}}, 2'($urandom % 4), 0, 1, n % 5 == 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #2000000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule